// File: doc/BRIEF.md
# Trace Buffer Fill Counter

This block keeps track of how much of a circular capture buffer of 64 lines, each 64 bits wide, holds valid data. It counts in half-line (32-bit) units, so a store of a full line advances the count by two and a store of a half line advances it by one. From the count it derives the line address for the next store and which half of that line comes next. When the count wraps past its top value the buffer is full, and the flag stays set for the rest of the session.

A capture session starts with an arm strobe, which clears the count and the full flag. The alignment mode decides what happens at the wrap. With end or mid alignment, counting goes on and the newest data overwrites the oldest lines. With begin alignment, the session stops: the block raises a one-cycle request to clear the arm bit and ignores all later stores. The count survives every reset except power-on, so after a system reset software can still read how many entries were captured before it.

Top module: `trace_fill_counter`

## Requirements
- R1: `cnt_img` bits 6:0 hold the count and bit 7 always reads 0. The block has no write path to the count.
- R2: A cycle with `por` high clears the count, the full flag, the armed state and `arm_clr_req` at the next clock edge.
- R3: A cycle with `sys_rst` high (and `por` low) ends any session and drops `arm_clr_req`. The count and the full flag keep their values.
- R4: A cycle with `arm_set` high (and no reset) clears the count and the full flag and arms the session. A store strobe in the same cycle is ignored.
- R5: While armed, `store_line` adds 2 to the count and `store_half` adds 1. When both are high, only `store_line` takes effect.
- R6: While not armed, store strobes leave the count and the full flag unchanged.
- R7: A store that carries the count past 127 sets `buf_full`. The flag stays set until power-on reset or an arm strobe.
- R8: With `align_mode` 0 (end), 1 (mid) or 3 (treated as end), counting continues after a wrap, modulo 128.
- R9: With `align_mode` 2 (begin), a wrapping store ends the session. `arm_clr_req` is high for exactly the one cycle after that edge, and later stores are ignored until the next arm strobe. The count keeps its wrapped value.
- R10: `wr_ptr` equals the count shifted right by one, and `wr_half` equals count bit 0. A `wr_half` of 0 selects the low half of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | Other system reset, synchronous, active high |
| arm_set | input | 1 | Strobe: the arm bit is being written to 1 |
| store_line | input | 1 | Strobe: a full 64-bit line is being stored |
| store_half | input | 1 | Strobe: a 32-bit half line is being stored |
| align_mode | input | 2 | Trigger alignment: 0 end, 1 mid, 2 begin, 3 end |
| cnt_img | output | 8 | Read-only count register image |
| buf_full | output | 1 | Buffer has wrapped at least once |
| wr_ptr | output | 6 | Line address for the next store |
| wr_half | output | 1 | Half of the addressed line for the next store (0 = low) |
| arm_clr_req | output | 1 | One-cycle request to clear the arm bit |

## Verification
The assertions check the reset and arm relations on every cycle: a system reset keeps the count and the full flag, an arm strobe clears both, the full flag is sticky, a wrap sets it, an unarmed cycle freezes the count, and the arm-clear request disarms and lasts one cycle. The exact increment for each mix of strobes, the modulo-128 arithmetic across several wraps, and the way each alignment mode behaves over a long store stream can only be shown by the bench's sweeps. The bench compares every output on every cycle against an arithmetic model in four alignment modes.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    typedef enum logic [1:0] {
        AL_END   = 2'd0,
        AL_MID   = 2'd1,
        AL_BEGIN = 2'd2,
        AL_RSV   = 2'd3
    } align_e;

    typedef struct packed {
        logic line;
        logic half;
    } store_t;

    // Increment in half-line units; a line store wins over a half store.
    function automatic logic [1:0] store_inc(input store_t st);
        if (st.line)      return 2'd2;
        else if (st.half) return 2'd1;
        else              return 2'd0;
    endfunction

    function automatic logic stops_on_wrap(input align_e m);
        return (m == AL_BEGIN);
    endfunction

endpackage

// File: rtl/tfc_step.sv
module tfc_step
    import tfc_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] cnt,
    input  store_t           st,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum  = {1'b0, cnt} + SUM_W'(store_inc(st));
        nxt  = sum[CNT_W-1:0];
        wrap = sum[CNT_W];
    end
endmodule

// File: rtl/tfc_arm_ctl.sv
module tfc_arm_ctl
    import tfc_pkg::*;
(
    input  logic   clk,
    input  logic   por,
    input  logic   sys_rst,
    input  logic   arm_set,
    input  logic   wrap_store,
    input  align_e mode,
    output logic   armed,
    output logic   arm_clr_req
);
    logic stop_now;

    always_comb stop_now = wrap_store && stops_on_wrap(mode);

    always_ff @(posedge clk) begin
        if (por || sys_rst) begin
            armed       <= 1'b0;
            arm_clr_req <= 1'b0;
        end else if (arm_set) begin
            armed       <= 1'b1;
            arm_clr_req <= 1'b0;
        end else begin
            arm_clr_req <= stop_now;
            if (stop_now) armed <= 1'b0;
        end
    end

    // R9: the arm-clear request always comes with a disarmed session
    a_r9_clr_disarms: assert property (@(posedge clk) disable iff (por)
        arm_clr_req |-> !armed);

    // R9: the request lasts a single cycle
    a_r9_clr_pulse: assert property (@(posedge clk) disable iff (por)
        arm_clr_req |=> !arm_clr_req);

    // R3: a system reset ends the session
    a_r3_sysrst_disarms: assert property (@(posedge clk) disable iff (por)
        sys_rst |=> (!armed && !arm_clr_req));
endmodule

// File: rtl/tfc_count_reg.sv
module tfc_count_reg #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             por,
    input  logic             sys_rst,
    input  logic             arm_set,
    input  logic             fire,
    input  logic [CNT_W-1:0] nxt,
    input  logic             wrap,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    always_ff @(posedge clk) begin
        if (por) begin
            cnt  <= '0;
            full <= 1'b0;
        end else if (sys_rst) begin
            cnt  <= cnt;
            full <= full;
        end else if (arm_set) begin
            cnt  <= '0;
            full <= 1'b0;
        end else if (fire) begin
            cnt <= nxt;
            if (wrap) full <= 1'b1;
        end
    end

    // R3: system reset leaves count and flag alone
    a_r3_sysrst_keeps: assert property (@(posedge clk) disable iff (por)
        sys_rst |=> (cnt == $past(cnt) && full == $past(full)));

    // R4: an arm strobe clears count and flag
    a_r4_arm_clears: assert property (@(posedge clk) disable iff (por)
        (arm_set && !sys_rst) |=> (cnt == '0 && !full));

    // R7: the full flag is sticky
    a_r7_full_sticky: assert property (@(posedge clk) disable iff (por)
        (full && !arm_set) |=> full);
endmodule

// File: rtl/trace_fill_counter.sv
module trace_fill_counter
    import tfc_pkg::*;
#(
    parameter int LINE_AW = 6,
    parameter int IMG_W   = 8
) (
    input  logic               clk,
    input  logic               por,
    input  logic               sys_rst,
    input  logic               arm_set,
    input  logic               store_line,
    input  logic               store_half,
    input  logic [1:0]         align_mode,
    output logic [IMG_W-1:0]   cnt_img,
    output logic               buf_full,
    output logic [LINE_AW-1:0] wr_ptr,
    output logic               wr_half,
    output logic               arm_clr_req
);
    localparam int CNT_W = LINE_AW + 1;
    localparam int PAD_W = IMG_W - CNT_W;

    store_t           st;
    align_e           mode;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic             wrap;
    logic             armed;
    logic             fire;

    always_comb begin
        st.line = store_line;
        st.half = store_half;
        mode    = align_e'(align_mode);
        fire    = armed && (store_line || store_half) && !arm_set && !sys_rst;
    end

    tfc_step #(.CNT_W(CNT_W)) u_step (
        .cnt  (cnt),
        .st   (st),
        .nxt  (nxt),
        .wrap (wrap)
    );

    tfc_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .por     (por),
        .sys_rst (sys_rst),
        .arm_set (arm_set),
        .fire    (fire),
        .nxt     (nxt),
        .wrap    (wrap),
        .cnt     (cnt),
        .full    (buf_full)
    );

    tfc_arm_ctl u_arm (
        .clk         (clk),
        .por         (por),
        .sys_rst     (sys_rst),
        .arm_set     (arm_set),
        .wrap_store  (fire && wrap),
        .mode        (mode),
        .armed       (armed),
        .arm_clr_req (arm_clr_req)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign cnt_img = {{PAD_W{1'b0}}, cnt};
        end else begin : g_nopad
            assign cnt_img = cnt[IMG_W-1:0];
        end
    endgenerate

    assign wr_ptr  = cnt[CNT_W-1:1];
    assign wr_half = cnt[0];

    // R6: an unarmed cycle without arm or reset freezes the count
    a_r6_unarmed_hold: assert property (@(posedge clk) disable iff (por)
        (!armed && !arm_set && !sys_rst) |=> $stable(cnt_img));

    // R7: a wrapping store raises the full flag
    a_r7_wrap_sets_full: assert property (@(posedge clk) disable iff (por)
        (fire && wrap) |=> buf_full);
endmodule

// File: tb/sim_trace_fill_counter.sv
module sim_trace_fill_counter;
    logic       clk = 1'b0;
    logic       por, sys_rst, arm_set, store_line, store_half;
    logic [1:0] align_mode;
    logic [7:0] cnt_img;
    logic       buf_full, wr_half, arm_clr_req;
    logic [5:0] wr_ptr;

    int n_cmp = 0;
    int n_bad = 0;
    int e_cnt = 0;
    bit e_full = 0, e_armed = 0, e_clr = 0;
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    trace_fill_counter u0 (
        .clk(clk), .por(por), .sys_rst(sys_rst), .arm_set(arm_set),
        .store_line(store_line), .store_half(store_half),
        .align_mode(align_mode), .cnt_img(cnt_img), .buf_full(buf_full),
        .wr_ptr(wr_ptr), .wr_half(wr_half), .arm_clr_req(arm_clr_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit l, input bit h, input bit a, input bit s,
                       input bit p, input string tag);
        int inc, sum;
        @(negedge clk);
        store_line = l; store_half = h; arm_set = a; sys_rst = s; por = p;
        @(posedge clk);
        if (p) begin
            e_cnt = 0; e_full = 0; e_armed = 0; e_clr = 0;
        end else if (s) begin
            e_armed = 0; e_clr = 0;
        end else if (a) begin
            e_cnt = 0; e_full = 0; e_armed = 1; e_clr = 0;
        end else begin
            e_clr = 0;
            if (e_armed && (l || h)) begin
                inc = l ? 2 : 1;
                sum = e_cnt + inc;
                if (sum >= 128) begin
                    e_full = 1;
                    if (align_mode == 2'd2) begin e_armed = 0; e_clr = 1; end
                end
                e_cnt = sum % 128;
            end
        end
        #2;
        chk(tag, int'(cnt_img[6:0]), e_cnt);
        chk("R1 bit7", int'(cnt_img[7]), 0);
        chk("R7 full", int'(buf_full), int'(e_full));
        chk("R10 ptr", int'(wr_ptr), e_cnt / 2);
        chk("R10 half", int'(wr_half), e_cnt % 2);
        chk("R9 clr", int'(arm_clr_req), int'(e_clr));
    endtask

    task automatic run_mix(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[1], lf[0], 1'b0, 1'b0, 1'b0, tag);
        end
    endtask

    initial begin
        por = 1; sys_rst = 0; arm_set = 0; store_line = 0; store_half = 0;
        align_mode = 2'd0;
        // R2: power-on reset state
        cyc(0, 0, 0, 0, 1, "R2 cnt");
        cyc(0, 0, 0, 0, 1, "R2 cnt");
        // R6: stores before any arm are ignored
        cyc(1, 0, 0, 0, 0, "R6 cnt");
        cyc(0, 1, 0, 0, 0, "R6 cnt");
        // R8 and R9: sweep every alignment mode over long mixed streams
        for (int m = 0; m < 4; m++) begin
            align_mode = 2'(m);
            // R4: a store in the arm cycle is ignored
            cyc(1, 1, 1, 0, 0, "R4 cnt");
            run_mix(260, (m == 2) ? "R9 cnt" : "R8 cnt");
            // R5: fixed strobe patterns after a fresh arm
            cyc(0, 0, 1, 0, 0, "R4 cnt");
            cyc(0, 1, 0, 0, 0, "R5 cnt");
            cyc(1, 0, 0, 0, 0, "R5 cnt");
            cyc(1, 1, 0, 0, 0, "R5 cnt");
            // R9: drive straight to the wrap with line stores
            for (int i = 0; i < 70; i++) cyc(1, 0, 0, 0, 0, "R5 cnt");
            cyc(0, 0, 0, 0, 0, "R9 cnt");
        end
        // R3: system reset mid-session keeps count and flag
        align_mode = 2'd0;
        cyc(0, 0, 1, 0, 0, "R4 cnt");
        run_mix(30, "R5 cnt");
        cyc(1, 0, 1, 1, 0, "R3 cnt");
        cyc(1, 1, 0, 0, 0, "R6 cnt");
        cyc(0, 1, 0, 0, 0, "R6 cnt");
        // R3: also after the buffer is full
        cyc(0, 0, 1, 0, 0, "R4 cnt");
        for (int i = 0; i < 66; i++) cyc(1, 0, 0, 0, 0, "R8 cnt");
        cyc(0, 0, 0, 1, 0, "R3 cnt");
        cyc(1, 0, 0, 0, 0, "R6 cnt");
        // R2: power-on reset clears everything
        cyc(0, 0, 0, 0, 1, "R2 cnt");
        cyc(1, 0, 0, 0, 0, "R6 cnt");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule